// File: doc/BRIEF.md
# Return Address Stack with Overflow Guard

This block holds return addresses for a small processor core. The core pushes an address on a call and pops one on a return. The current top entry is always visible on a read port. The block watches for two faults: a push while every entry is occupied (overflow), and a pop while no entry is occupied (underflow). Each fault sets its own sticky status flag. The full flag also rises on the push that occupies the last free entry.

A configuration enable decides what happens next. With the enable set, a fault also produces a one-cycle request to reset the core. With the enable clear, the flags are still set, but no request is made.

The flags survive the core reset that the block may itself request, so software can read the cause afterwards. Only a per-flag software clear strobe or the power-on reset removes them. Stack depth and address width are parameters.

Top module: `rstk_guard`

## Requirements
- R1: Pushed addresses come back in last-in first-out order; `top_o` shows the most recently pushed live entry, and shows zero when the stack is empty.
- R2: `full_o` rises on the clock edge of the push that makes the entry count equal DEPTH; pushes below that leave it low.
- R3: A push while DEPTH entries are held writes nothing, leaves the pointer unchanged and sets `full_o`; the stored entries later pop out unchanged.
- R4: A pop while empty sets `unf_o`, leaves the pointer at zero and keeps `top_o` at zero.
- R5: With `rst_en_i` = 1, an overflow or underflow drives `rst_req_o` high for exactly the one cycle after the faulting edge, with the matching flag already set in that cycle.
- R6: With `rst_en_i` = 0, overflow and underflow set their flags but `rst_req_o` stays low.
- R7: Each flag stays set until its own clear strobe (`clr_full_i` for `full_o`, `clr_unf_i` for `unf_o`) or power-on reset. A clear strobe leaves the other flag untouched. When a set event and the clear strobe fall in the same cycle, the set wins.
- R8: `core_rst_i` (synchronous) empties the stack, drops `rst_req_o` and ignores push/pop in that cycle, but keeps both flags. `por_n` low (asynchronous) clears the pointer, both flags and the request.
- R9: A push and a pop in the same cycle act as a pop alone; the pushed address is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| core_rst_i | input | 1 | Core reset, synchronous; empties the stack but keeps the flags |
| push_i | input | 1 | Push strobe |
| push_addr_i | input | AW | Address to push |
| pop_i | input | 1 | Pop strobe |
| top_o | output | AW | Top entry, zero when empty |
| rst_en_i | input | 1 | Configuration: faults request a reset |
| clr_full_i | input | 1 | Software clear of the full flag |
| clr_unf_i | input | 1 | Software clear of the underflow flag |
| full_o | output | 1 | Sticky full/overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with DEPTH = 4 and AW = 12. At that depth the stack fills in four pushes, so the filling push, an overflow push and a full drain are all reached in a few cycles. The 12-bit width leaves room for distinct marker addresses, which show that an overflow push does not overwrite an entry and that a discarded simultaneous push never appears. Both settings of the reset enable are applied to both fault kinds.

// File: rtl/rstk_guard.sv
module rstk_guard #(
  parameter int DEPTH = 8,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          core_rst_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          pop_i,
  output logic [AW-1:0] top_o,
  input  logic          rst_en_i,
  input  logic          clr_full_i,
  input  logic          clr_unf_i,
  output logic          full_o,
  output logic          unf_o,
  output logic          rst_req_o
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr;
  logic do_push, do_pop, is_empty, is_full, ovf, udf, fills;

  assign do_pop   = !core_rst_i && pop_i;
  assign do_push  = !core_rst_i && push_i && !pop_i;
  assign is_empty = (ptr == '0);
  assign is_full  = (ptr == CAP);
  assign ovf      = do_push && is_full;
  assign udf      = do_pop && is_empty;
  assign fills    = do_push && (ptr == CAP - 1'b1);
  assign top_o    = is_empty ? '0 : mem[IW'(ptr - 1'b1)];

  always_ff @(posedge clk)
    if (do_push && !is_full) mem[IW'(ptr)] <= push_addr_i;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                    ptr <= '0;
    else if (core_rst_i)           ptr <= '0;
    else if (do_pop && !is_empty)  ptr <= ptr - 1'b1;
    else if (do_push && !is_full)  ptr <= ptr + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      full_o    <= 1'b0;
      unf_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      full_o    <= (full_o && !clr_full_i) || fills || ovf;
      unf_o     <= (unf_o && !clr_unf_i) || udf;
      rst_req_o <= rst_en_i && (ovf || udf);
    end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!por_n) ptr <= CAP);
  a_r1_push_lands: assert property (@(posedge clk) disable iff (!por_n)
    (do_push && !is_full) |=> (top_o == $past(push_addr_i)));
  a_r4_udf_flag: assert property (@(posedge clk) disable iff (!por_n)
    udf |=> (unf_o && top_o == '0));
  a_r6_req_needs_en: assert property (@(posedge clk) disable iff (!por_n)
    rst_req_o |-> $past(rst_en_i));
  a_r5_flag_with_req: assert property (@(posedge clk) disable iff (!por_n)
    rst_req_o |-> (full_o || unf_o));
  a_r7_full_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (full_o && !clr_full_i) |=> full_o);
  a_r7_unf_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (unf_o && !clr_unf_i) |=> unf_o);
endmodule

// File: tb/rstk_guard_test.sv
module rstk_guard_test;
  localparam int  DEPTH = 4;
  localparam int  AW    = 12;
  localparam time TCLK  = 10ns;

  logic clk = 1'b0, por_n = 1'b0, core_rst_i = 1'b0;
  logic push_i = 1'b0, pop_i = 1'b0, rst_en_i = 1'b0;
  logic clr_full_i = 1'b0, clr_unf_i = 1'b0;
  logic [AW-1:0] push_addr_i = '0;
  logic [AW-1:0] top_o;
  logic full_o, unf_o, rst_req_o;
  int checks = 0, fails = 0;

  always #(TCLK/2) clk = ~clk;

  rstk_guard #(.DEPTH(DEPTH), .AW(AW)) uut (
    .clk(clk), .por_n(por_n), .core_rst_i(core_rst_i), .push_i(push_i),
    .push_addr_i(push_addr_i), .pop_i(pop_i), .top_o(top_o), .rst_en_i(rst_en_i),
    .clr_full_i(clr_full_i), .clr_unf_i(clr_unf_i), .full_o(full_o),
    .unf_o(unf_o), .rst_req_o(rst_req_o));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive strobes for one cycle (from a negedge), return at the next negedge.
  task automatic cyc(logic ps, logic [AW-1:0] a, logic pp,
                     logic cf = 0, logic cu = 0, logic cr = 0);
    push_i = ps; push_addr_i = a; pop_i = pp;
    clr_full_i = cf; clr_unf_i = cu; core_rst_i = cr;
    @(negedge clk);
    push_i = 0; pop_i = 0; clr_full_i = 0; clr_unf_i = 0; core_rst_i = 0;
  endtask

  task automatic por();
    por_n = 0; @(negedge clk); por_n = 1; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R8 reset top", top_o, 0);
    chk("R8 reset full", full_o, 0);
    chk("R8 reset unf", unf_o, 0);
    chk("R8 reset req", rst_req_o, 0);
  endtask

  task automatic t_lifo();
    cyc(1, 12'h111, 0); cyc(1, 12'h222, 0);
    chk("R1 top after two pushes", top_o, 12'h222);
    cyc(0, 0, 1); chk("R1 pop order", top_o, 12'h111);
    cyc(0, 0, 1); chk("R1 empty top zero", top_o, 0);
    chk("R1 no underflow", unf_o, 0);
  endtask

  task automatic t_overflow_en();
    rst_en_i = 1;
    for (int i = 1; i <= 3; i++) cyc(1, AW'(12'hA00 + i), 0);
    chk("R2 not full at DEPTH-1", full_o, 0);
    cyc(1, 12'hA04, 0);
    chk("R2 full on filling push", full_o, 1);
    chk("R5 no req on fill", rst_req_o, 0);
    cyc(0, 0, 0, 1); chk("R7 clear full", full_o, 0);
    cyc(1, 12'hBAD, 0);
    chk("R3 overflow sets full", full_o, 1);
    chk("R5 req on overflow", rst_req_o, 1);
    chk("R3 top unchanged", top_o, 12'hA04);
    cyc(0, 0, 0); chk("R5 req one cycle", rst_req_o, 0);
    for (int i = 4; i >= 1; i--) begin
      chk("R3 entries intact", top_o, 12'hA00 + i);
      cyc(0, 0, 1);
    end
    chk("R3 drained", top_o, 0);
    cyc(0, 0, 1);
    chk("R5 req on underflow", rst_req_o, 1);
    chk("R4 unf set", unf_o, 1);
    cyc(0, 0, 0, 0, 1);
  endtask

  task automatic t_noen();
    rst_en_i = 0;
    cyc(0, 0, 1);
    chk("R6 unf set without en", unf_o, 1);
    chk("R6 no req on underflow", rst_req_o, 0);
    chk("R4 top zero", top_o, 0);
    cyc(1, 12'h055, 0); chk("R4 pointer stayed zero", top_o, 12'h055);
    cyc(0, 0, 1); chk("R4 back to empty", top_o, 0);
    for (int i = 0; i < DEPTH; i++) cyc(1, AW'(i + 1), 0);
    cyc(1, 12'hEEE, 0);
    chk("R6 full without en", full_o, 1);
    chk("R6 no req on overflow", rst_req_o, 0);
  endtask

  task automatic t_clear();
    cyc(0, 0, 0, 1);
    chk("R7 clr_full clears full", full_o, 0);
    chk("R7 clr_full leaves unf", unf_o, 1);
    cyc(0, 0, 0, 0, 1); chk("R7 clr_unf clears unf", unf_o, 0);
    cyc(1, 12'h777, 0, 1);
    chk("R7 set wins over clear", full_o, 1);
  endtask

  task automatic t_core_rst();
    cyc(0, 0, 1, 0, 0, 1);
    chk("R8 core reset empties", top_o, 0);
    chk("R8 core reset keeps full", full_o, 1);
    chk("R8 core reset ignores pop", unf_o, 0);
    cyc(1, 12'h0AA, 0); chk("R8 usable after core reset", top_o, 12'h0AA);
    cyc(0, 0, 1); cyc(0, 0, 1);
    chk("R8 unf before por", unf_o, 1);
    por();
    chk("R8 por clears full", full_o, 0);
    chk("R8 por clears unf", unf_o, 0);
  endtask

  task automatic t_simul();
    cyc(1, 12'h003, 0); cyc(1, 12'h004, 0);
    cyc(1, 12'h009, 1); chk("R9 push+pop acts as pop", top_o, 12'h003);
    cyc(0, 0, 1); chk("R9 pushed address discarded", top_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1; @(negedge clk);
    t_reset(); t_lifo(); t_overflow_en(); t_noen(); t_clear(); t_core_rst(); t_simul();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule